// File: doc/BRIEF.md
# Indexed Control Word Register Interface

This block sits behind the frame deserializer of a stereo audio converter. Once per sample frame the host places a 16-bit control word in the control time slot. The block decodes that word. It keeps three control flags and a 4-bit index, and it writes the data byte into one of sixteen 8-bit index registers. Three of those registers are guarded by the mode-change flag: the format register, the miscellaneous register, and the calibration bit of the configuration register. Writes to them take effect only when the incoming word itself has that flag set. While the mode-change flag is held, the DAC mute output is asserted.

On the outbound side the block supplies the word for the status/readback slot. Normally this is the external status word. A control word with its read flag set turns the next readback opportunity into a readback word instead. That word carries the control flags and index in the upper byte and the addressed register in the lower byte. The readback slot sits late in the frame (slot 3) when the slot-select input is 0, and in slot 0 of the following frame when it is 1. A change of slot-select while a request is waiting has defined effects.

Top module: `icw_ctrl_if`

## Requirements
- R1: After reset the control state equals C000h: the clear-overrange and mode-change flags are 1, the read flag is 0, the index is 0, all index registers are 0, and no readback is pending.
- R2: A word strobed in slot 0 loads clear-overrange from bit 15, mode-change from bit 14, read from bit 13 and the index from bits 11:8, visible the next cycle. Bit 12 has no effect.
- R3: A word with bit 14 clear writes nothing to register 8 or register 12. Written to register 9, it leaves bit 3 unchanged and writes the other bits.
- R4: A word with bit 13 clear and bit 14 set writes its full data byte to any register, including 8, 9 and 12. A word with bits 13 and 14 clear writes to any other register.
- R5: dac_mute is high exactly while the stored mode-change flag is high.
- R6: A word with bit 13 set writes no register. With slot-select 0, the next slot 3 of the same frame carries tx_is_rb=1. Its tx_word is {stored bits 15:13, 1'b0, index, register[index]}, and the readback is sent once only.
- R7: With slot-select 1, a read request is answered in the next slot 0, which is in the following frame, with the same word format.
- R8: A readback slot without a pending request carries status_word, with tx_is_rb=0.
- R9: If slot-select rises from 0 to 1 while a slot-3 readback is pending, the readback goes out both in that slot 3 and in the next slot 0.
- R10: If slot-select falls from 1 to 0 while a slot-0 readback is pending, that request is dropped.
- R11: tx_en is high only during a slot strobe. It covers slot 3 when slot-select is 0, slot 0 when it is 1, and any slot holding a pending readback.
- R12: A frame_start strobe drops a slot-3 readback that was not yet sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each sample frame |
| slot_vld | input | 1 | One-cycle strobe marking a time slot |
| slot_idx | input | 3 | Number of the slot being strobed |
| ctl_word | input | 16 | Inbound word, decoded when slot_idx is 0 |
| tssel | input | 1 | Slot-select: 0 readback in slot 3, 1 readback in slot 0 |
| status_word | input | 16 | Status word sent when no readback is due |
| reg_flat | output | 128 | Index registers, register n at bits 8n+7:8n |
| clor | output | 1 | Stored clear-overrange flag |
| mce | output | 1 | Stored mode-change flag |
| dac_mute | output | 1 | DAC mute request |
| tx_en | output | 1 | Current slot is a status/readback slot |
| tx_is_rb | output | 1 | tx_word holds readback data |
| tx_word | output | 16 | Outbound word for the current slot |

## Verification
The bench drives slot-select edges between a request and its readback slot. A design that ignores the rising edge sends the readback once instead of twice. A design that ignores the falling edge leaks stale data into a later slot 0. Protected writes are sent with bit 14 clear. A design missing the bit mask on register 9 would either drop the other bits or overwrite the calibration bit. Requests are also placed across a frame boundary and repeated in the same slot, which exposes readbacks that are never cleared and requests that survive frame_start.

// File: rtl/icw_pkg.sv
package icw_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 8;
    localparam int NREG   = 1 << IDX_W;

    // Inbound word layout, most significant field first
    typedef struct packed {
        logic              clor;
        logic              mce;
        logic              rreq;
        logic              rsvd;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } ctl_word_t;

    // Retained control state
    typedef struct packed {
        logic             clor;
        logic             mce;
        logic             rreq;
        logic [IDX_W-1:0] idx;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{clor: 1'b1, mce: 1'b1, rreq: 1'b0, idx: '0};

    // Bit-enable for a write into register idx under a given mode-change flag
    function automatic logic [DATA_W-1:0] wr_mask(
        input int   idx,
        input logic mce_w,
        input int   fmt_idx,
        input int   ifc_idx,
        input int   misc_idx,
        input int   acal_bit
    );
        logic [DATA_W-1:0] m;
        m = '1;
        if (!mce_w) begin
            if (idx == fmt_idx || idx == misc_idx) begin
                m = '0;
            end else if (idx == ifc_idx) begin
                m = ~(DATA_W'(1) << acal_bit);
            end
        end
        return m;
    endfunction

    // Readback word: control fields above, register data below
    function automatic logic [WORD_W-1:0] rb_pack(
        input ctl_state_t       st,
        input logic [DATA_W-1:0] d
    );
        return {st.clor, st.mce, st.rreq, 1'b0, st.idx, d};
    endfunction

endpackage

// File: rtl/icw_word_dec.sv
module icw_word_dec
    import icw_pkg::*;
#(
    parameter int SLOT_W    = 3,
    parameter int CTRL_SLOT = 0
) (
    input  logic                slot_vld,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [WORD_W-1:0]   ctl_word,
    output logic                stb,
    output logic                wr_en,
    output logic                rd_req,
    output ctl_word_t           word
);

    always_comb begin
        word   = ctl_word_t'(ctl_word);
        stb    = slot_vld && (slot_idx == SLOT_W'(CTRL_SLOT));
        wr_en  = stb && !word.rreq;
        rd_req = stb && word.rreq;
    end

endmodule

// File: rtl/icw_regfile.sv
module icw_regfile
    import icw_pkg::*;
#(
    parameter int FMT_IDX  = 8,
    parameter int IFC_IDX  = 9,
    parameter int MISC_IDX = 12,
    parameter int ACAL_BIT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   wr_mce,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NREG*DATA_W-1:0] regs_flat
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic              hit;
        logic [DATA_W-1:0] mask;

        always_comb begin
            hit  = wr_en && (wr_idx == IDX_W'(g));
            mask = wr_mask(g, wr_mce, FMT_IDX, IFC_IDX, MISC_IDX, ACAL_BIT);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (hit) begin
                regs[g] <= (regs[g] & ~mask) | (wr_data & mask);
            end
        end

        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/icw_rb_sched.sv
module icw_rb_sched #(
    parameter int SLOT_W     = 3,
    parameter int EARLY_SLOT = 0,
    parameter int LATE_SLOT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              slot_vld,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              tssel,
    input  logic              rd_req,
    output logic              tx_en,
    output logic              tx_is_rb
);

    logic tssel_q;
    logic pend_late, pend_early;
    logic at_late, at_early;
    logic serve_late, serve_early;
    logic ts_rise, ts_fall;
    logic pend_late_n, pend_early_n;

    always_comb begin
        at_late     = slot_vld && (slot_idx == SLOT_W'(LATE_SLOT));
        at_early    = slot_vld && (slot_idx == SLOT_W'(EARLY_SLOT));
        serve_late  = at_late && pend_late;
        serve_early = at_early && pend_early;
        tx_en       = (at_late && (!tssel || pend_late)) ||
                      (at_early && (tssel || pend_early));
        tx_is_rb    = serve_late || serve_early;
        ts_rise     = tssel && !tssel_q;
        ts_fall     = !tssel && tssel_q;
    end

    always_comb begin
        pend_late_n  = pend_late;
        pend_early_n = pend_early;
        if (frame_start || serve_late) begin
            pend_late_n = 1'b0;
        end
        if (serve_early) begin
            pend_early_n = 1'b0;
        end
        if (ts_rise && pend_late) begin
            pend_early_n = 1'b1;
        end
        if (ts_fall) begin
            pend_early_n = 1'b0;
        end
        if (rd_req) begin
            if (tssel) begin
                pend_early_n = 1'b1;
            end else begin
                pend_late_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tssel_q    <= 1'b0;
            pend_late  <= 1'b0;
            pend_early <= 1'b0;
        end else begin
            tssel_q    <= tssel;
            pend_late  <= pend_late_n;
            pend_early <= pend_early_n;
        end
    end

endmodule

// File: rtl/icw_ctrl_if.sv
module icw_ctrl_if
    import icw_pkg::*;
#(
    parameter int NUM_SLOTS  = 6,
    parameter int CTRL_SLOT  = 0,
    parameter int EARLY_SLOT = 0,
    parameter int LATE_SLOT  = 3,
    parameter int FMT_IDX    = 8,
    parameter int IFC_IDX    = 9,
    parameter int MISC_IDX   = 12,
    parameter int ACAL_BIT   = 3,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_start,
    input  logic                   slot_vld,
    input  logic [SLOT_W-1:0]      slot_idx,
    input  logic [WORD_W-1:0]      ctl_word,
    input  logic                   tssel,
    input  logic [WORD_W-1:0]      status_word,
    output logic [NREG*DATA_W-1:0] reg_flat,
    output logic                   clor,
    output logic                   mce,
    output logic                   dac_mute,
    output logic                   tx_en,
    output logic                   tx_is_rb,
    output logic [WORD_W-1:0]      tx_word
);

    ctl_word_t         word;
    ctl_state_t        st;
    logic              stb, wr_en, rd_req;
    logic [DATA_W-1:0] rd_data;

    icw_word_dec #(
        .SLOT_W    (SLOT_W),
        .CTRL_SLOT (CTRL_SLOT)
    ) u_dec (
        .slot_vld (slot_vld),
        .slot_idx (slot_idx),
        .ctl_word (ctl_word),
        .stb      (stb),
        .wr_en    (wr_en),
        .rd_req   (rd_req),
        .word     (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= CTL_RESET;
        end else if (stb) begin
            st <= '{clor: word.clor, mce: word.mce, rreq: word.rreq, idx: word.idx};
        end
    end

    icw_regfile #(
        .FMT_IDX  (FMT_IDX),
        .IFC_IDX  (IFC_IDX),
        .MISC_IDX (MISC_IDX),
        .ACAL_BIT (ACAL_BIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (word.idx),
        .wr_data   (word.data),
        .wr_mce    (word.mce),
        .rd_idx    (st.idx),
        .rd_data   (rd_data),
        .regs_flat (reg_flat)
    );

    icw_rb_sched #(
        .SLOT_W     (SLOT_W),
        .EARLY_SLOT (EARLY_SLOT),
        .LATE_SLOT  (LATE_SLOT)
    ) u_sched (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .slot_vld    (slot_vld),
        .slot_idx    (slot_idx),
        .tssel       (tssel),
        .rd_req      (rd_req),
        .tx_en       (tx_en),
        .tx_is_rb    (tx_is_rb)
    );

    always_comb begin
        clor     = st.clor;
        mce      = st.mce;
        dac_mute = st.mce;
        tx_word  = tx_is_rb ? rb_pack(st, rd_data) : status_word;
    end

endmodule

// File: rtl/icw_ctrl_if_chk.sv
module icw_ctrl_if_chk
    import icw_pkg::*;
#(
    parameter int SLOT_W    = 3,
    parameter int CTRL_SLOT = 0,
    parameter int FMT_IDX   = 8,
    parameter int IFC_IDX   = 9,
    parameter int ACAL_BIT  = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   slot_vld,
    input logic [SLOT_W-1:0]      slot_idx,
    input logic [WORD_W-1:0]      ctl_word,
    input logic [WORD_W-1:0]      status_word,
    input logic [NREG*DATA_W-1:0] reg_flat,
    input logic                   mce,
    input logic                   tx_en,
    input logic                   tx_is_rb,
    input logic [WORD_W-1:0]      tx_word
);

    logic c_stb;
    assign c_stb = slot_vld && (slot_idx == SLOT_W'(CTRL_SLOT));

    p_mce_load_r2: assert property (@(posedge clk) disable iff (rst)
        c_stb |=> (mce == $past(ctl_word[14])));

    p_fmt_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (c_stb && !ctl_word[14] && ctl_word[11:8] == IDX_W'(FMT_IDX))
        |=> $stable(reg_flat[FMT_IDX*DATA_W +: DATA_W]));

    p_acal_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (c_stb && !ctl_word[14] && ctl_word[11:8] == IDX_W'(IFC_IDX))
        |=> $stable(reg_flat[IFC_IDX*DATA_W + ACAL_BIT]));

    p_read_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        (c_stb && ctl_word[13]) |=> $stable(reg_flat));

    p_rb_in_tx_slot_r6: assert property (@(posedge clk) disable iff (rst)
        tx_is_rb |-> tx_en);

    p_status_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !tx_is_rb) |-> (tx_word == status_word));

    p_tx_needs_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        !slot_vld |-> !tx_en);

endmodule

bind icw_ctrl_if icw_ctrl_if_chk #(
    .SLOT_W    (SLOT_W),
    .CTRL_SLOT (CTRL_SLOT),
    .FMT_IDX   (FMT_IDX),
    .IFC_IDX   (IFC_IDX),
    .ACAL_BIT  (ACAL_BIT)
) u_chk (.*);

// File: tb/test_icw_ctrl_if.sv
module test_icw_ctrl_if;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_start = 1'b0;
    logic         slot_vld = 1'b0;
    logic [2:0]   slot_idx = '0;
    logic [15:0]  ctl_word = '0;
    logic         tssel = 1'b0;
    logic [15:0]  status_word = 16'h1234;
    logic [127:0] reg_flat;
    logic         clor, mce, dac_mute, tx_en, tx_is_rb;
    logic [15:0]  tx_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic        obs_en, obs_rb;
    logic [15:0] obs_word;

    // reference model state
    logic [7:0] m_reg [16];
    logic       m_clor, m_mce, m_rreq, m_p3, m_p0, m_tsp;
    logic [3:0] m_ia;

    always #4 clk = ~clk;

    icw_ctrl_if i_icw_ctrl_if (
        .clk (clk), .rst (rst), .frame_start (frame_start),
        .slot_vld (slot_vld), .slot_idx (slot_idx), .ctl_word (ctl_word),
        .tssel (tssel), .status_word (status_word), .reg_flat (reg_flat),
        .clor (clor), .mce (mce), .dac_mute (dac_mute),
        .tx_en (tx_en), .tx_is_rb (tx_is_rb), .tx_word (tx_word)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (rst) begin
            m_clor = 1; m_mce = 1; m_rreq = 0; m_ia = 0;
            m_p3 = 0; m_p0 = 0; m_tsp = 0;
            for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        end else begin
            logic en, rb, stb, rise, fall;
            logic [15:0] w;
            logic [127:0] flat;
            int k;
            en = slot_vld && ((slot_idx == 3 && (!tssel || m_p3)) ||
                              (slot_idx == 0 && (tssel || m_p0)));
            rb = en && ((slot_idx == 3) ? m_p3 : m_p0);
            w  = rb ? {m_clor, m_mce, m_rreq, 1'b0, m_ia, m_reg[m_ia]} : status_word;
            for (int i = 0; i < 16; i++) flat[i*8 +: 8] = m_reg[i];
            chk("R11 tx_en", tx_en, en);
            chk("R6 tx_is_rb", tx_is_rb, rb);
            if (en) chk("R8 tx_word", tx_word, w);
            chk("R2 mce", mce, m_mce);
            chk("R2 clor", clor, m_clor);
            chk("R5 dac_mute", dac_mute, m_mce);
            chk("R3 registers", reg_flat, flat);
            // advance model to the coming edge
            stb  = slot_vld && slot_idx == 0;
            rise = tssel && !m_tsp;
            fall = !tssel && m_tsp;
            if (frame_start || (slot_vld && slot_idx == 3 && m_p3)) m_p3 = 0;
            if (slot_vld && slot_idx == 0 && m_p0) m_p0 = 0;
            if (rise && m_p3) m_p0 = 1;
            if (fall) m_p0 = 0;
            if (stb) begin
                k = ctl_word[11:8];
                if (ctl_word[13]) begin
                    if (tssel) m_p0 = 1; else m_p3 = 1;
                end else if (ctl_word[14] || !(k == 8 || k == 12 || k == 9)) begin
                    m_reg[k] = ctl_word[7:0];
                end else if (k == 9) begin
                    m_reg[k] = {ctl_word[7:4], m_reg[k][3], ctl_word[2:0]};
                end
                m_clor = ctl_word[15]; m_mce = ctl_word[14];
                m_rreq = ctl_word[13]; m_ia = ctl_word[11:8];
            end
            m_tsp = tssel;
        end
    end

    task automatic cyc(input logic v, input int idx, input logic [15:0] w, input logic fs);
        @(posedge clk); #1;
        slot_vld = v; slot_idx = 3'(idx); ctl_word = w; frame_start = fs;
        @(negedge clk);
        obs_en = tx_en; obs_rb = tx_is_rb; obs_word = tx_word;
    endtask

    task automatic idle();
        cyc(0, 0, 16'h0, 0);
    endtask

    task automatic set_ts(input logic b);
        @(posedge clk); #1;
        tssel = b; slot_vld = 0; frame_start = 0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] rg(input int i);
        return reg_flat[i*8 +: 8];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mce", mce, 1'b1);
        chk("R1 clor", clor, 1'b1);
        chk("R1 regs", reg_flat, 128'h0);
        chk("R1 tx_en idle", tx_en, 1'b0);

        // R2 plain write, R11 gating, R8 status
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'h82A5, 0);
        chk("R11 slot0 under tssel0", obs_en, 1'b0);
        idle();
        chk("R2 reg2", rg(2), 8'hA5);
        chk("R2 mce loaded", mce, 1'b0);
        chk("R5 mute low", dac_mute, 1'b0);
        cyc(1, 1, 16'h0, 0);
        chk("R11 slot1", obs_en, 1'b0);
        cyc(1, 3, 16'h0, 0);
        chk("R8 en", obs_en, 1'b1);
        chk("R8 rb", obs_rb, 1'b0);
        chk("R8 word", obs_word, 16'h1234);

        // R2 reserved bit ignored
        cyc(1, 0, 16'h1377, 0); idle();
        chk("R2 reserved bit", rg(3), 8'h77);
        chk("R2 reserved mce", mce, 1'b0);

        // R3 / R4 protection
        cyc(1, 0, 16'h083C, 0); idle();
        chk("R3 fmt locked", rg(8), 8'h00);
        cyc(1, 0, 16'h0CFF, 0); idle();
        chk("R3 misc locked", rg(12), 8'h00);
        cyc(1, 0, 16'h09FF, 0); idle();
        chk("R3 acal masked", rg(9), 8'hF7);
        cyc(1, 0, 16'h483C, 0); idle();
        chk("R4 fmt open", rg(8), 8'h3C);
        chk("R5 mute high", dac_mute, 1'b1);
        cyc(1, 0, 16'h4908, 0); idle();
        chk("R4 acal open", rg(9), 8'h08);
        cyc(1, 0, 16'h0900, 0); idle();
        chk("R3 acal kept", rg(9), 8'h08);
        cyc(1, 0, 16'h4C81, 0); idle();
        chk("R4 misc open", rg(12), 8'h81);

        // R6 readback in slot 3
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'hA255, 0); idle();
        chk("R6 no write", rg(2), 8'hA5);
        cyc(1, 3, 16'h0, 0);
        chk("R6 rb flag", obs_rb, 1'b1);
        chk("R6 rb word", obs_word, 16'hA2A5);
        cyc(1, 3, 16'h0, 0);
        chk("R6 served once", obs_rb, 1'b0);

        // R7 readback in next slot 0
        set_ts(1); idle();
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'hA255, 0);
        chk("R8 slot0 status", obs_word, 16'h1234);
        cyc(1, 3, 16'h0, 0);
        chk("R11 slot3 under tssel1", obs_en, 1'b0);
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'h8000, 0);
        chk("R7 rb flag", obs_rb, 1'b1);
        chk("R7 rb word", obs_word, 16'hA2A5);

        // R9 rise sends twice
        set_ts(0);
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'hA200, 0);
        set_ts(1);
        cyc(1, 3, 16'h0, 0);
        chk("R9 slot3 rb", obs_rb, 1'b1);
        chk("R9 slot3 word", obs_word, 16'hA2A5);
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'h8000, 0);
        chk("R9 slot0 rb", obs_rb, 1'b1);
        chk("R9 slot0 word", obs_word, 16'hA2A5);
        cyc(1, 0, 16'h8000, 0);
        chk("R9 no third", obs_rb, 1'b0);

        // R10 fall drops
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'hA300, 0);
        set_ts(0);
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'h8000, 0);
        chk("R10 slot0 silent", obs_en, 1'b0);
        cyc(1, 3, 16'h0, 0);
        chk("R10 dropped", obs_rb, 1'b0);

        // R12 frame_start expiry, then a served request
        cyc(0, 0, 16'h0, 1);
        cyc(1, 0, 16'hA300, 0);
        cyc(0, 0, 16'h0, 1);
        cyc(1, 3, 16'h0, 0);
        chk("R12 expired", obs_rb, 1'b0);
        cyc(1, 0, 16'hA300, 0);
        cyc(1, 3, 16'h0, 0);
        chk("R6 ia3 word", obs_word, 16'hA377);
        idle(); idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule